// File: doc/BRIEF.md
# Dead-Time Half-Bridge Output Steering

This block turns a digital sawtooth into the two complementary gate enables of a half bridge. Each sawtooth period has two parts. The first is a charge phase, whose length in clocks is the current charge-length value. The second is a discharge phase of programmable length. A toggle flop sends alternate charge phases to the low-side and high-side enables, so the two sides get exactly equal on-time. Both enables stay low for the whole discharge phase, and that phase is the dead time.

The charge length is not taken directly from an input. An internal ramp starts at a start value on every enable. It then steps one count at a time toward a target picked by the operating mode: a preheat setpoint, a minimum-frequency (ignition) setpoint, or a run setpoint. It takes one step every programmable number of periods. The run setpoint may sit on either side of the ignition setpoint, so the ramp moves in both directions. A longer charge phase means a lower switching frequency. A new charge or dead length is taken only when a period begins, so no pulse is ever cut short or stretched. After every enable the first pulse goes to the low side. A one-clock strobe marks each falling edge of the low-side enable for an external sampler.

Top module: `bridge_deadtime_steer`

## Requirements
- R1: Successive charge phases drive `lo`, `hi`, `lo`, `hi`, ... in strict alternation. Each pulse is high for exactly the charge length of its period, in clocks.
- R2: Between two consecutive pulses, both `lo` and `hi` are low for exactly the dead length, in clocks. `lo` and `hi` are never high together.
- R3: After every enable, the first pulse is on `lo`. `lo` rises on the first clock edge at which `en` is sampled high.
- R4: `lo` and `hi` are low from the first clock edge at which `en` is sampled low. While disabled, the sawtooth, the toggle flop and the ramp are held in their start state.
- R5: On enable, the charge length starts at `start_len`. After every `step_periods` completed periods it moves one count toward the mode target, and it stops at the target. The first `step_periods` pulses use `start_len`.
- R6: The mode selects the ramp target: `mode`=0 selects `preheat_len`; `mode`=1 selects `min_len`; `mode`=2 or 3 selects `run_len`. The ramp moves up or down as needed to reach the target.
- R7: A change to a setpoint or to `dead_len` has no effect on the period already in progress. It first applies to the next period.
- R8: `lo_fall` is high for exactly the one clock in which `lo` first reads low after being high, and at no other time.
- R9: A value of 0 on a charge length, on `dead_len` or on `step_periods` acts as 1.
- R10: While `rst` is high, `hi`, `lo` and `lo_fall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low holds the bridge off (lockout or fault) |
| mode | input | 2 | Operating mode: 0 preheat, 1 ignition, 2/3 run |
| start_len | input | LEN_W | Charge length loaded on each enable |
| preheat_len | input | LEN_W | Preheat target charge length |
| min_len | input | LEN_W | Ignition (minimum-frequency) target charge length |
| run_len | input | LEN_W | Run target charge length |
| dead_len | input | DEAD_W | Discharge (dead-time) length in clocks |
| step_periods | input | STEP_W | Periods per one-count ramp step |
| hi | output | 1 | High-side gate enable |
| lo | output | 1 | Low-side gate enable |
| lo_fall | output | 1 | One-clock strobe on each falling edge of `lo` |

## Verification
The output registers add one clock to every result. `lo` goes high on the first edge at which `en` is sampled high, and both outputs drop on the first edge at which `en` is sampled low. `lo_fall` is high in the same clock in which `lo` first reads low. A ramp step computed at the end of a period already sets the length of the very next pulse. The bench drives inputs and samples outputs on the falling clock edge. It measures every pulse width and every gap in whole clocks and compares each one against a queue of pulses that it predicted before enabling. The enable latency, the disable response and the strobe are checked at fixed falling edges, one clock after the stimulus.

// File: rtl/bds_pkg.sv
package bds_pkg;
  typedef enum logic [1:0] {
    MODE_PREHEAT = 2'd0,
    MODE_IGNITE  = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_RUN_ALT = 2'd3
  } op_mode_e;

  typedef enum logic {
    PH_CHARGE = 1'b0,
    PH_DEAD   = 1'b1
  } saw_phase_e;
endpackage

// File: rtl/bds_ramp.sv
module bds_ramp #(
  parameter int LEN_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  bds_pkg::op_mode_e    mode,
  input  logic [LEN_W-1:0]     start_len,
  input  logic [LEN_W-1:0]     preheat_len,
  input  logic [LEN_W-1:0]     min_len,
  input  logic [LEN_W-1:0]     run_len,
  input  logic [STEP_W-1:0]    step_periods,
  input  logic                 wrap,
  output logic [LEN_W-1:0]     len_next
);
  import bds_pkg::*;

  logic [LEN_W-1:0]  cur;
  logic [LEN_W-1:0]  target;
  logic [STEP_W-1:0] divcnt;
  logic [STEP_W:0]   dnext;
  logic              at_tgt;
  logic              step_now;

  // R6: the mode picks the target
  always_comb begin
    case (mode)
      MODE_PREHEAT: target = preheat_len;
      MODE_IGNITE:  target = min_len;
      default:      target = run_len;
    endcase
  end

  // R5, R9: a step is due after step_periods wraps; 0 acts as 1
  assign dnext    = {1'b0, divcnt} + (STEP_W+1)'(1);
  assign at_tgt   = (cur == target);
  assign step_now = en && wrap && !at_tgt && (dnext >= {1'b0, step_periods});

  // lookahead: the sawtooth latches this value at the same wrap edge
  always_comb begin
    if (!en)
      len_next = start_len;
    else if (step_now)
      len_next = (cur < target) ? cur + LEN_W'(1) : cur - LEN_W'(1);
    else
      len_next = cur;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cur    <= start_len;
      divcnt <= '0;
    end else if (wrap) begin
      cur <= len_next;
      if (at_tgt || step_now)
        divcnt <= '0;
      else
        divcnt <= dnext[STEP_W-1:0];
    end
  end

  // R5: while enabled the length moves by at most one count per clock
  a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |->
      (cur == $past(cur) || cur == $past(cur) + LEN_W'(1) || cur == $past(cur) - LEN_W'(1)));
endmodule

// File: rtl/bds_saw.sv
module bds_saw #(
  parameter int LEN_W  = 12,
  parameter int DEAD_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [LEN_W-1:0]       len_in,
  input  logic [DEAD_W-1:0]      dead_in,
  output bds_pkg::saw_phase_e    phase,
  output logic                   chg_end,
  output logic                   wrap
);
  import bds_pkg::*;

  localparam int CNT_W = (LEN_W > DEAD_W) ? LEN_W : DEAD_W;

  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  cur_chg;
  logic [DEAD_W-1:0] cur_dead;
  logic [LEN_W-1:0]  eff_len;
  logic [DEAD_W-1:0] eff_dead;
  logic              chg_last;
  logic              dead_last;

  // R9: zero lengths act as one clock
  assign eff_len  = (len_in  == '0) ? LEN_W'(1)  : len_in;
  assign eff_dead = (dead_in == '0) ? DEAD_W'(1) : dead_in;

  assign chg_last  = (cnt == CNT_W'(cur_chg)  - CNT_W'(1));
  assign dead_last = (cnt == CNT_W'(cur_dead) - CNT_W'(1));
  assign chg_end   = en && (phase == PH_CHARGE) && chg_last;
  assign wrap      = en && (phase == PH_DEAD) && dead_last;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase    <= PH_CHARGE;
      cnt      <= '0;
      cur_chg  <= eff_len;
      cur_dead <= eff_dead;
    end else if (phase == PH_CHARGE) begin
      if (chg_last) begin
        phase <= PH_DEAD;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      if (dead_last) begin
        // R7: new lengths are taken only at a period boundary
        phase    <= PH_CHARGE;
        cnt      <= '0;
        cur_chg  <= eff_len;
        cur_dead <= eff_dead;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R7: the latched lengths hold for the whole period
  a_r7_hold_len: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(wrap)) |-> ($stable(cur_chg) && $stable(cur_dead)));
endmodule

// File: rtl/bds_steer.sv
module bds_steer (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  bds_pkg::saw_phase_e  phase,
  input  logic                 chg_end,
  output logic                 hi,
  output logic                 lo,
  output logic                 lo_fall
);
  import bds_pkg::*;

  logic sel;   // 0: low side, 1: high side
  logic lo_d;
  logic hi_d;
  logic lo_seen;

  assign lo_d = (phase == PH_CHARGE) && !sel;
  assign hi_d = (phase == PH_CHARGE) &&  sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= 1'b0;
      lo      <= 1'b0;
      hi      <= 1'b0;
      lo_fall <= 1'b0;
    end else if (!en) begin
      // R3, R4: outputs off, toggle back to the low side
      sel     <= 1'b0;
      lo      <= 1'b0;
      hi      <= 1'b0;
      lo_fall <= lo;
    end else begin
      // R1: toggle at each end of charge
      sel     <= sel ^ chg_end;
      lo      <= lo_d;
      hi      <= hi_d;
      lo_fall <= lo & ~lo_d;   // R8
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) lo_seen <= 1'b0;
    else if (lo)    lo_seen <= 1'b1;
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));
  a_r2_dead_blank: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_DEAD) |=> (!hi && !lo));
  a_r3_lo_first: assert property (@(posedge clk) disable iff (rst)
    hi |-> lo_seen);
  a_r4_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hi && !lo));
  a_r8_strobe: assert property (@(posedge clk) disable iff (rst)
    lo_fall |-> (!lo && $past(lo)));
endmodule

// File: rtl/bridge_deadtime_steer.sv
module bridge_deadtime_steer #(
  parameter int LEN_W  = 12,
  parameter int DEAD_W = 8,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [LEN_W-1:0]  preheat_len,
  input  logic [LEN_W-1:0]  min_len,
  input  logic [LEN_W-1:0]  run_len,
  input  logic [DEAD_W-1:0] dead_len,
  input  logic [STEP_W-1:0] step_periods,
  output logic              hi,
  output logic              lo,
  output logic              lo_fall
);
  import bds_pkg::*;

  op_mode_e         mode_e;
  saw_phase_e       phase;
  logic             chg_end;
  logic             wrap;
  logic [LEN_W-1:0] len_next;

  assign mode_e = op_mode_e'(mode);

  bds_ramp #(.LEN_W(LEN_W), .STEP_W(STEP_W)) u_ramp (
    .clk(clk), .rst(rst), .en(en), .mode(mode_e),
    .start_len(start_len), .preheat_len(preheat_len),
    .min_len(min_len), .run_len(run_len),
    .step_periods(step_periods), .wrap(wrap), .len_next(len_next)
  );

  bds_saw #(.LEN_W(LEN_W), .DEAD_W(DEAD_W)) u_saw (
    .clk(clk), .rst(rst), .en(en), .len_in(len_next), .dead_in(dead_len),
    .phase(phase), .chg_end(chg_end), .wrap(wrap)
  );

  bds_steer u_steer (
    .clk(clk), .rst(rst), .en(en), .phase(phase), .chg_end(chg_end),
    .hi(hi), .lo(lo), .lo_fall(lo_fall)
  );
endmodule

// File: tb/tb_bridge_deadtime_steer.sv
`timescale 1ns/1ps
module tb_bridge_deadtime_steer;
  localparam int LEN_W = 12, DEAD_W = 8, STEP_W = 8;

  typedef struct packed {
    logic        side;   // 0 lo, 1 hi
    logic        first;
    logic [15:0] width;
    logic [15:0] gap;
    logic [7:0]  req;
  } pulse_t;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [1:0] mode = '0;
  logic [LEN_W-1:0] start_len = '0, preheat_len = '0, min_len = '0, run_len = '0;
  logic [DEAD_W-1:0] dead_len = '0;
  logic [STEP_W-1:0] step_periods = '0;
  logic hi, lo, lo_fall;

  int checks = 0, fails = 0;
  pulse_t expq[$];
  logic mon_on = 1'b0;

  always #2 clk = ~clk;

  bridge_deadtime_steer #(.LEN_W(LEN_W), .DEAD_W(DEAD_W), .STEP_W(STEP_W)) dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .start_len(start_len),
    .preheat_len(preheat_len), .min_len(min_len), .run_len(run_len),
    .dead_len(dead_len), .step_periods(step_periods),
    .hi(hi), .lo(lo), .lo_fall(lo_fall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // predict pulses from R5/R6/R9
  task automatic push_ramp(input int md, input int st, input int ph, input int mn,
                           input int rn, input int dl, input int n, input int count,
                           input int req);
    int w = st;
    int ne = (n == 0) ? 1 : n;
    int tg = (md == 0) ? ph : (md == 1) ? mn : rn;
    pulse_t p;
    for (int k = 0; k < count; k++) begin
      p.side  = logic'(k % 2);
      p.first = (k == 0);
      p.width = 16'((w == 0) ? 1 : w);
      p.gap   = 16'((dl == 0) ? 1 : dl);
      p.req   = 8'(req);
      expq.push_back(p);
      if (((k + 1) % ne) == 0 && w != tg) w += (tg > w) ? 1 : -1;
    end
  endtask

  task automatic setup(input int md, input int st, input int ph, input int mn,
                       input int rn, input int dl, input int n);
    @(negedge clk);
    mode = 2'(md); start_len = LEN_W'(st); preheat_len = LEN_W'(ph);
    min_len = LEN_W'(mn); run_len = LEN_W'(rn); dead_len = DEAD_W'(dl);
    step_periods = STEP_W'(n);
  endtask

  task automatic begin_session();
    repeat (2) @(negedge clk);
    mon_on = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    // R3: lo up on the first edge that sampled en
    check(lo === 1'b1 && hi === 1'b0, "R3 first pulse lo", int'(lo), 1);
  endtask

  task automatic end_session();
    wait (expq.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
    en = 1'b0;
    @(negedge clk);
    // R4: both off one edge after en low
    check(lo === 1'b0 && hi === 1'b0, "R4 off after disable", int'({hi, lo}), 0);
    repeat (3) @(negedge clk);
    check(lo === 1'b0 && hi === 1'b0, "R4 stays off", int'({hi, lo}), 0);
  endtask

  // monitor: measure pulses and gaps, compare with queue; R8 strobe
  initial begin : monitor
    bit in_p = 0, side = 0, first = 1, prev_lo = 0;
    int width = 0, gap = 0, gap_at = 0;
    pulse_t e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_lo && !lo)
          check(lo_fall === 1'b1, "R8 strobe on lo fall", int'(lo_fall), 1);
        else if (lo_fall !== 1'b0)
          check(1'b0, "R8 spurious strobe", int'(lo_fall), 0);
      end
      prev_lo = lo;
      if (!mon_on) begin
        in_p = 0; first = 1; gap = 0;
      end else if (lo || hi) begin
        if (lo && hi) check(1'b0, "R2 both high", 3, 0);
        if (in_p) width++;
        else begin
          in_p = 1; side = hi; width = 1; gap_at = gap;
        end
      end else begin
        if (in_p) begin
          in_p = 0;
          if (expq.size() == 0) check(1'b0, "R1 unexpected pulse", width, 0);
          else begin
            e = expq.pop_front();
            check(side == e.side, $sformatf("R1 side (R%0d)", e.req), int'(side), int'(e.side));
            check(width == int'(e.width), $sformatf("R%0d width", e.req), width, int'(e.width));
            if (!first)
              check(gap_at == int'(e.gap), "R2 dead gap", gap_at, int'(e.gap));
          end
          first = 0;
          gap = 1;
        end else gap++;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    pulse_t p;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(lo === 1'b0 && hi === 1'b0 && lo_fall === 1'b0, "R10 reset outputs", int'({hi, lo, lo_fall}), 0);
    rst = 1'b0;

    // R1/R2/R3: steady alternation, width 5 dead 3
    setup(0, 5, 5, 9, 9, 3, 1);
    push_ramp(0, 5, 5, 9, 9, 3, 1, 6, 1);
    begin_session(); end_session();

    // R5: preheat ramp up 6->9, two periods per step
    setup(0, 6, 9, 20, 20, 2, 2);
    push_ramp(0, 6, 9, 20, 20, 2, 2, 9, 5);
    begin_session(); end_session();

    // R6: ignition target min_len (up 9->12)
    setup(1, 9, 4, 12, 3, 2, 1);
    push_ramp(1, 9, 4, 12, 3, 2, 1, 5, 6);
    begin_session(); end_session();

    // R6: run target below start (down 10->7)
    setup(2, 10, 4, 20, 7, 2, 1);
    push_ramp(2, 10, 4, 20, 7, 2, 1, 5, 6);
    begin_session(); end_session();

    // R6: mode 3 also selects run_len
    setup(3, 4, 9, 9, 5, 2, 1);
    push_ramp(3, 4, 9, 9, 5, 2, 1, 3, 6);
    begin_session(); end_session();

    // R7: setpoint and dead changes mid pulse apply to the next period only
    setup(0, 6, 6, 20, 20, 3, 1);
    p = '{side: 1'b0, first: 1'b1, width: 16'd6, gap: 16'd0, req: 8'd7}; expq.push_back(p);
    p = '{side: 1'b1, first: 1'b0, width: 16'd7, gap: 16'd3, req: 8'd7}; expq.push_back(p);
    p = '{side: 1'b0, first: 1'b0, width: 16'd7, gap: 16'd5, req: 8'd7}; expq.push_back(p);
    begin_session();
    @(negedge clk);
    preheat_len = LEN_W'(7);
    dead_len = DEAD_W'(5);
    end_session();

    // R9: zero lengths and zero step count act as one
    setup(0, 0, 0, 0, 0, 0, 0);
    push_ramp(0, 0, 0, 0, 0, 0, 0, 4, 9);
    begin_session(); end_session();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule